// File: doc/BRIEF.md
# Dual-Lane Folded AES-128 Encryption Engine

This block encrypts two independent 128-bit plaintext blocks under one shared 128-bit key, using AES-128 (ten rounds). It is an iterative design with a 32-bit datapath. Each clock it produces one new state column. Every round therefore costs four cycles per block. The two blocks, called lane A and lane B, take turns on the datapath. Lane A runs one full round pass, then lane B runs the same round, and both lanes use the same round key.

The operation starts with a one-cycle pulse on `start`. That pulse captures the key and both plaintexts. The first pass is the initial key whitening, done one column at a time. Each of the ten rounds after it merges substitution and column mixing into one byte-to-word lookup per row. The row rotation is done by choosing which source column each row byte is read from. The final round uses the substituted bytes directly, with no mixing. Round keys are derived on the fly, one per round, from the previous one. When both ciphertexts are ready, `done` goes high for a single cycle. The ciphertext ports then hold their values until the next accepted start.

Top module: `aes_dual_fold`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0 and both `ct_a` and `ct_b` are all zeros.
- R2: `ct_a` equals the AES-128 encryption of `pt_a` under `key`. Blocks are big-endian: bits [127:96] hold column 0, and the top byte of each column is row 0.
- R3: `ct_b` equals the AES-128 encryption of `pt_b` under the same key. It is computed independently of lane A, and equal plaintexts give equal ciphertexts.
- R4: If `start` is sampled high at rising edge E while the engine is idle, `done` is high right after rising edge E+88 and low at every sampled point before it.
- R5: `done` is high for exactly one cycle. After it falls, `ct_a` and `ct_b` keep their values until another start is accepted.
- R6: A `start` pulse that arrives while an encryption is running is ignored. The running key and plaintexts are not replaced, and the completion time does not change.
- R7: Each accepted start restarts the key schedule from the newly presented key, including the round-constant sequence 01,02,04,...,1B,36. A run under a new key is therefore correct no matter which key the previous run used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins an encryption when the engine is idle |
| key | input | 128 | Cipher key, captured on an accepted start |
| pt_a | input | 128 | Lane A plaintext, captured on an accepted start |
| pt_b | input | 128 | Lane B plaintext, captured on an accepted start |
| ct_a | output | 128 | Lane A ciphertext, valid from `done` until the next start |
| ct_b | output | 128 | Lane B ciphertext, valid from `done` until the next start |
| done | output | 1 | One-cycle flag: both ciphertexts are valid |

## Verification
The hardest case to reach from the ports is a restart request that lands in the middle of a run, while the lanes are alternating rounds. In that case the key and plaintext inputs must not leak into the live state. The stimulus pulses `start` twenty cycles into a run while it presents a different key and different plaintexts, and leaves those inputs changed afterwards. It then checks that both ciphertexts still match the original inputs and that `done` arrives after the same 88 edges. Lane separation is tested by giving the two lanes different and identical plaintexts. The key-schedule restart is tested by running vectors back to back with alternating keys.

// File: rtl/aes_fold_pkg.sv
package aes_fold_pkg;

    localparam int COL_W      = 32;
    localparam int NUM_COLS   = 4;
    localparam int BLK_W      = COL_W * NUM_COLS;
    localparam int NUM_LANES  = 2;
    localparam int NUM_ROUNDS = 10;
    localparam int RND_W      = $clog2(NUM_ROUNDS + 1);
    localparam int COL_IDX_W  = $clog2(NUM_COLS);

    typedef logic [COL_W-1:0] col_t;
    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [7:0]       byte_t;

    typedef enum logic [1:0] {
        PH_WHITEN = 2'd0,
        PH_MIX    = 2'd1,
        PH_FINAL  = 2'd2
    } phase_e;

    typedef struct packed {
        logic                 busy;
        logic [RND_W-1:0]     rnd;
        logic                 lane;
        logic [COL_IDX_W-1:0] col;
    } seq_t;

    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t p;
        byte_t x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = xtime(x);
        end
        return p;
    endfunction

    // multiplicative inverse as a^254; maps 0 to 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = a;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t sbox(input byte_t a);
        byte_t v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    // combined substitute-and-mix word for a row-0 source byte: {2s, s, s, 3s}
    function automatic col_t tword(input byte_t s);
        return {xtime(s), s, s, xtime(s) ^ s};
    endfunction

    function automatic col_t rot_r8(input col_t w);
        return {w[7:0], w[31:8]};
    endfunction

    function automatic col_t col_of(input blk_t s, input int idx);
        return s[BLK_W-1-COL_W*idx -: COL_W];
    endfunction

    function automatic byte_t byte_of(input col_t w, input int row);
        return w[COL_W-1-8*row -: 8];
    endfunction

endpackage

// File: rtl/aes_key_sched.sv
module aes_key_sched
    import aes_fold_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  blk_t key_in,
    input  logic step,
    output blk_t rk
);

    blk_t  rk_q;
    byte_t rcon_q;
    col_t  w_in [NUM_COLS];
    col_t  w_nx [NUM_COLS];
    col_t  rot_w;
    col_t  sub_w;
    col_t  mix_t;

    for (genvar g = 0; g < NUM_COLS; g++) begin : g_words
        assign w_in[g] = col_of(rk_q, g);
    end

    assign rot_w = {w_in[NUM_COLS-1][23:0], w_in[NUM_COLS-1][31:24]};

    for (genvar g = 0; g < 4; g++) begin : g_subword
        assign sub_w[COL_W-1-8*g -: 8] = sbox(byte_of(rot_w, g));
    end

    assign mix_t = sub_w ^ {rcon_q, 24'h000000};

    always_comb begin
        w_nx[0] = w_in[0] ^ mix_t;
        for (int i = 1; i < NUM_COLS; i++) begin
            w_nx[i] = w_in[i] ^ w_nx[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rk_q   <= '0;
            rcon_q <= 8'h01;
        end else if (load) begin
            rk_q   <= key_in;
            rcon_q <= 8'h01;
        end else if (step) begin
            rk_q   <= {w_nx[0], w_nx[1], w_nx[2], w_nx[3]};
            rcon_q <= xtime(rcon_q);
        end
    end

    assign rk = rk_q;

    // R7: every accepted start restarts the round constant at 01
    assert_rcon_restart_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (rcon_q == 8'h01));

    // R7: the round key moves only on a load or a round step
    assert_key_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> (rk_q == $past(rk_q)));

endmodule

// File: rtl/aes_seq.sv
module aes_seq
    import aes_fold_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output seq_t   seq,
    output phase_e phase,
    output logic   load,
    output logic   commit,
    output logic   key_step,
    output logic   done
);

    seq_t q;
    logic done_q;
    logic pass_end;
    logic last_rnd;
    logic finish;

    assign pass_end = q.busy && (q.col == COL_IDX_W'(NUM_COLS - 1));
    assign last_rnd = (q.rnd == RND_W'(NUM_ROUNDS));
    assign finish   = pass_end && q.lane && last_rnd;
    assign load     = !q.busy && start;
    assign commit   = pass_end;
    assign key_step = pass_end && q.lane && !last_rnd;

    always_comb begin
        if (q.rnd == '0)   phase = PH_WHITEN;
        else if (last_rnd) phase = PH_FINAL;
        else               phase = PH_MIX;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!q.busy) begin
                if (start) begin
                    q.busy <= 1'b1;
                    q.rnd  <= '0;
                    q.lane <= 1'b0;
                    q.col  <= '0;
                end
            end else begin
                q.col <= q.col + 1'b1;
                if (pass_end) begin
                    q.lane <= ~q.lane;
                    if (q.lane) begin
                        if (last_rnd) begin
                            q.busy <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            q.rnd <= q.rnd + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign seq  = q;
    assign done = done_q;

    // R6, R4: a running encryption keeps stepping one column per cycle, start or not
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (q.busy && !finish) |=> (q.busy && q.col == $past(q.col) + 1'b1));

    // R4: the round counter never runs past the final round
    assert_round_bound_R4: assert property (@(posedge clk) disable iff (rst)
        q.busy |-> (q.rnd <= RND_W'(NUM_ROUNDS)));

    // R5: completion flag lasts a single cycle
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R5: completion is only flagged once the engine has gone idle
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !q.busy);

endmodule

// File: rtl/aes_col_unit.sv
module aes_col_unit
    import aes_fold_pkg::*;
(
    input  phase_e               phase,
    input  blk_t                 st,
    input  blk_t                 rk,
    input  logic [COL_IDX_W-1:0] col,
    output col_t                 res
);

    byte_t src [4];
    byte_t sub [4];
    col_t  mixed;
    col_t  plain;
    col_t  picked;

    // row r reads from column col+r: this is the row rotation
    for (genvar g = 0; g < 4; g++) begin : g_rows
        logic [COL_IDX_W-1:0] idx;
        assign idx    = col + COL_IDX_W'(g);
        assign src[g] = byte_of(col_of(st, int'(idx)), g);
        assign sub[g] = sbox(src[g]);
    end

    assign mixed = tword(sub[0])
                 ^ rot_r8(tword(sub[1]))
                 ^ rot_r8(rot_r8(tword(sub[2])))
                 ^ rot_r8(rot_r8(rot_r8(tword(sub[3]))));

    assign plain = {sub[0], sub[1], sub[2], sub[3]};

    always_comb begin
        unique case (phase)
            PH_WHITEN: picked = col_of(st, int'(col));
            PH_FINAL:  picked = plain;
            default:   picked = mixed;
        endcase
    end

    assign res = picked ^ col_of(rk, int'(col));

endmodule

// File: rtl/aes_dual_fold.sv
module aes_dual_fold
    import aes_fold_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [127:0] key,
    input  logic [127:0] pt_a,
    input  logic [127:0] pt_b,
    output logic [127:0] ct_a,
    output logic [127:0] ct_b,
    output logic         done
);

    seq_t   seq;
    phase_e phase;
    logic   load;
    logic   commit;
    logic   key_step;
    blk_t   rk;
    blk_t   st [NUM_LANES];
    blk_t   pt_in [NUM_LANES];
    blk_t   cur_st;
    col_t   res;
    col_t   part0, part1, part2;

    assign pt_in[0] = pt_a;
    assign pt_in[1] = pt_b;

    aes_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .seq      (seq),
        .phase    (phase),
        .load     (load),
        .commit   (commit),
        .key_step (key_step),
        .done     (done)
    );

    aes_key_sched u_key (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .key_in (key),
        .step   (key_step),
        .rk     (rk)
    );

    assign cur_st = st[seq.lane];

    aes_col_unit u_col (
        .phase (phase),
        .st    (cur_st),
        .rk    (rk),
        .col   (seq.col),
        .res   (res)
    );

    // partial result columns of the current pass; the source state stays intact
    always_ff @(posedge clk) begin
        if (rst) begin
            part0 <= '0;
            part1 <= '0;
            part2 <= '0;
        end else if (seq.busy) begin
            case (seq.col)
                2'd0:    part0 <= res;
                2'd1:    part1 <= res;
                2'd2:    part2 <= res;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                st[g] <= '0;
            end else if (load) begin
                st[g] <= pt_in[g];
            end else if (commit && seq.lane == 1'(g)) begin
                st[g] <= {part0, part1, part2, res};
            end
        end

        // R3: a lane's state is untouched while the other lane owns the datapath
        assert_lane_isolated_R3: assert property (@(posedge clk) disable iff (rst)
            (seq.busy && seq.lane != 1'(g)) |=> (st[g] == $past(st[g])));

        // R5: results hold while idle with no new start
        assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (!seq.busy && !start) |=> (st[g] == $past(st[g])));
    end

    assign ct_a = st[0];
    assign ct_b = st[1];

endmodule

// File: tb/sim_aes_dual_fold.sv
module sim_aes_dual_fold;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    localparam int LATENCY = 88;

    localparam logic [127:0] K1 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] K2 = 128'h000102030405060708090a0b0c0d0e0f;

    localparam logic [127:0] V_KEY [NV] = '{K1, K1, K1, K2, 128'h0};
    localparam logic [127:0] V_PA  [NV] = '{
        128'h6bc1bee22e409f96e93d7e117393172a,
        128'h30c81c46a35ce411e5fbc1191a0a52ef,
        128'h3243f6a8885a308d313198a2e0370734,
        128'h00112233445566778899aabbccddeeff,
        128'h0};
    localparam logic [127:0] V_PB  [NV] = '{
        128'hae2d8a571e03ac9c9eb76fac45af8e51,
        128'hf69f2445df4f9b17ad2b417be66c3710,
        128'h6bc1bee22e409f96e93d7e117393172a,
        128'h00112233445566778899aabbccddeeff,
        128'h0};
    localparam logic [127:0] V_CA  [NV] = '{
        128'h3ad77bb40d7a3660a89ecaf32466ef97,
        128'h43b1cd7f598ece23881b00e3ed030688,
        128'h3925841d02dc09fbdc118597196a0b32,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        128'h66e94bd4ef8a2c3b884cfa59ca342b2e};
    localparam logic [127:0] V_CB  [NV] = '{
        128'hf5d3d58503b9699de785895a96fdbaaf,
        128'h7b0c785e27e8ad3f8223207104725dd4,
        128'h3ad77bb40d7a3660a89ecaf32466ef97,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        128'h66e94bd4ef8a2c3b884cfa59ca342b2e};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] pt_a = '0;
    logic [127:0] pt_b = '0;
    logic [127:0] ct_a;
    logic [127:0] ct_b;
    logic         done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    aes_dual_fold u0 (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .key   (key),
        .pt_a  (pt_a),
        .pt_b  (pt_b),
        .ct_a  (ct_a),
        .ct_b  (ct_b),
        .done  (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // start a run at a falling edge; optionally inject a start pulse mid-run
    task automatic run(input logic [127:0] k, input logic [127:0] a, input logic [127:0] b,
                       input bit inject, output int cyc);
        key = k; pt_a = a; pt_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (inject && cyc == 20) begin
                key = 128'h0; pt_a = 128'h0; pt_b = 128'hffff; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [127:0] hold_a;
        logic [127:0] hold_b;

        // R1: reset state, with start held high during reset
        start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done after reset", {127'h0, done}, 128'h0);
        chk("R1 ct_a after reset", ct_a, 128'h0);
        chk("R1 ct_b after reset", ct_b, 128'h0);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done stays low", {127'h0, done}, 128'h0);

        // R2, R3, R7: vector table, keys alternate between runs
        for (int v = 0; v < NV; v++) begin
            run(V_KEY[v], V_PA[v], V_PB[v], 1'b0, cyc);
            chk($sformatf("R2 lane A vector %0d", v), ct_a, V_CA[v]);
            chk($sformatf("R3 lane B vector %0d", v), ct_b, V_CB[v]);
            chk($sformatf("R4 latency vector %0d", v), 128'(cyc), 128'(LATENCY));
            if (v > 0 && V_KEY[v] != V_KEY[v-1])
                chk($sformatf("R7 rekeyed vector %0d", v), ct_a, V_CA[v]);
        end

        // R5: single-cycle done and held results
        run(V_KEY[0], V_PA[0], V_PB[0], 1'b0, cyc);
        hold_a = ct_a;
        hold_b = ct_b;
        pt_a = 128'h1; pt_b = 128'h2; key = 128'h3;
        @(posedge clk);
        @(negedge clk);
        chk("R5 done falls after one cycle", {127'h0, done}, 128'h0);
        repeat (5) @(negedge clk);
        chk("R5 ct_a held", ct_a, hold_a);
        chk("R5 ct_b held", ct_b, hold_b);

        // R6: start while busy is ignored
        run(V_KEY[1], V_PA[1], V_PB[1], 1'b1, cyc);
        chk("R6 lane A unaffected by busy start", ct_a, V_CA[1]);
        chk("R6 lane B unaffected by busy start", ct_b, V_CB[1]);
        chk("R6 latency unchanged", 128'(cyc), 128'(LATENCY));

        // R3: lanes swapped give swapped results
        run(V_KEY[0], V_PB[0], V_PA[0], 1'b0, cyc);
        chk("R3 swapped lane A", ct_a, V_CB[0]);
        chk("R3 swapped lane B", ct_b, V_CA[0]);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule